// File: doc/BRIEF.md
# Serial Port Status and Interrupt Controller

This block owns the status flags and interrupt requests of a synchronous serial port that can run in network (time-slot) mode. It watches the moment a word is moved into the transmit shift register and the last-slot strobes from the framing logic. From these it keeps four sticky flags: transmit underrun, transmit data request, transmit last slot and receive last slot. The shift registers, the clock generation and the FIFO storage are outside the block. It gets the FIFO fill level and the slot strobes as inputs.

Software reaches the block through a small register bus. Two styles of clearing are supported. The underrun flag and the data-request flag clear through a sequence: a status read, then a write to the data register of every enabled transmitter. A write to the time-slot register also clears both flags. The two last-slot flags are write-1-to-clear. Each interrupt output is a registered AND of a flag and its enable.

The block also holds off external frame syncs after the port is enabled. A frame sync is accepted only after four bit-clock ticks.

Register map (8-bit data, 3-bit address):
- Address 0 is status. Reading it gives bit 0 underrun, bit 1 data request, bit 2 transmit last slot and bit 3 receive last slot. Writing it clears bit 2 and/or bit 3 where the written bit is 1.
- Address 1 is control. Bits 2:0 are the transmitter enables and bit 3 is the receiver enable. Bit 4 is the transmit interrupt enable, bit 5 the transmit-last-slot interrupt enable and bit 6 the receive-last-slot interrupt enable. Bit 7 enables the transmit FIFO.
- Address 2 is the time-slot register. It acts only as a write strobe and reads as 0.
- Address 3 is configuration. Bits 3:0 hold the watermark and bit 7 selects network mode.
- Addresses 4, 5 and 6 are the transmit data registers of transmitters 0, 1 and 2. Here only the write event is used, and they read as 0.

Top module: `ssi_irq_ctrl`

## Requirements
- R1: After reset, every status bit, every interrupt output, the control and configuration registers, and fs_acc_o are 0.
- R2: A load event (tx_load_i) with tx_avail_i low sets the underrun flag (status bit 0). A load with tx_avail_i high does not set it.
- R3: Underrun and data request clear only in this order: first a status read while the flag is set, then a write to the data register (address 4+i) of every enabled transmitter i. Writes made before the read do not count, and a partial set of writes does not clear the flag.
- R4: A write to the time-slot register (address 2) clears both underrun and data request.
- R5: When the FIFO is disabled (control bit 7 = 0), every load event sets data request (status bit 1).
- R6: When the FIFO is enabled, a load event sets data request only if fifo_lvl_i is less than or equal to the watermark (configuration bits 3:0).
- R7: In network mode (configuration bit 7 = 1), tx_last_slot_i sets status bit 2. Outside network mode it has no effect. Bit 2 clears only when 1 is written to bit 2 of address 0.
- R8: In network mode, rx_last_slot_i sets status bit 3. Outside network mode it has no effect. Bit 3 clears only when 1 is written to bit 3 of address 0.
- R9: Each interrupt output equals its flag ANDed with its enable, registered one cycle after the flag. irq_tx_err_o and irq_tx_o use control bit 4, irq_tls_o uses bit 5 and irq_rls_o uses bit 6.
- R10: If a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: fs_acc_o follows ext_fs_i only after at least four bit_tick_i pulses, counted while some transmitter or the receiver is enabled. With every enable off the count restarts and fs_acc_o stays 0.
- R12: If the underrun or data-request flag is set again while its clear sequence is armed, the sequence is cancelled. A new status read is then needed before writes count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_load_i | input | 1 | A word moves to the transmit shift register this cycle |
| tx_avail_i | input | 1 | Data present in the enabled holding register or FIFO at the load |
| fifo_lvl_i | input | LvlW | Transmit FIFO fill level |
| tx_last_slot_i | input | 1 | Start of the last slot of the transmit frame |
| rx_last_slot_i | input | 1 | End of the last slot of the receive frame |
| bit_tick_i | input | 1 | One pulse per bit clock |
| ext_fs_i | input | 1 | External frame sync |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational from bus_addr_i) |
| fs_acc_o | output | 1 | Accepted external frame sync |
| irq_tx_err_o | output | 1 | Underrun interrupt |
| irq_tx_o | output | 1 | Transmit data interrupt |
| irq_tls_o | output | 1 | Transmit last slot interrupt |
| irq_rls_o | output | 1 | Receive last slot interrupt |

## Verification
A wrong armed or write-collection state in the clear sequence shows up on irq_tx_err_o and irq_tx_o. The interrupt either drops one write too early or fails to drop two cycles after the final write. The bench therefore tries every transmitter-enable mask and every point where the sequence can be cut short. A bad watermark comparison shows up in the status read one cycle after the load. That comparison is swept over the full fill-level range for several watermarks. A frame-sync counter that is off by one shows up on fs_acc_o at the exact tick where acceptance begins.

// File: rtl/ssi_irq_pkg.sv
package ssi_irq_pkg;
  localparam int DataW = 8;
  localparam int AddrW = 3;

  localparam logic [AddrW-1:0] ADDR_STAT  = 3'd0;
  localparam logic [AddrW-1:0] ADDR_CTRL  = 3'd1;
  localparam logic [AddrW-1:0] ADDR_TSLOT = 3'd2;
  localparam logic [AddrW-1:0] ADDR_CFG   = 3'd3;
  localparam logic [AddrW-1:0] ADDR_TXD0  = 3'd4;

  localparam int CTRL_RXEN  = 3;
  localparam int CTRL_TIE   = 4;
  localparam int CTRL_TLIE  = 5;
  localparam int CTRL_RLIE  = 6;
  localparam int CTRL_FIFO  = 7;
  localparam int CFG_NET    = 7;

  localparam int STAT_TLS = 2;
  localparam int STAT_RLS = 3;
endpackage

// File: rtl/ssi_seq_clear.sv
module ssi_seq_clear #(
  parameter int NumTx = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             rd_i,
  input  logic [NumTx-1:0] wr_i,
  input  logic [NumTx-1:0] en_i,
  input  logic             force_clr_i,
  output logic             flag_o
);
  logic             flag_q, armed_q;
  logic [NumTx-1:0] done_q;
  logic             seq_clr;

  // every enabled transmitter written since arming (the write in this cycle counts)
  assign seq_clr = armed_q & (&(done_q | wr_i | ~en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= '0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
      done_q  <= '0;
    end else if (seq_clr || force_clr_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= '0;
    end else begin
      if (rd_i && flag_q) armed_q <= 1'b1;
      if (armed_q) done_q <= done_q | (wr_i & en_i);
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_cancel_arm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !armed_q);
  p_clear_needs_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !armed_q && !force_clr_i) |=> flag_q);
endmodule

// File: rtl/ssi_fs_gate.sv
module ssi_fs_gate #(
  parameter int Setup = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_en_i,
  input  logic tick_i,
  input  logic fs_i,
  output logic fs_o
);
  localparam int CntW = $clog2(Setup + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(Setup);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!any_en_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != CntMax)  cnt_q <= cnt_q + 1'b1;
  end

  assign fs_o = fs_i & any_en_i & (cnt_q == CntMax);

  p_fs_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en_i |=> !fs_o);
  p_fs_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_en_i) |-> !fs_o);
endmodule

// File: rtl/ssi_irq_ctrl.sv
module ssi_irq_ctrl
  import ssi_irq_pkg::*;
#(
  parameter int NumTx   = 3,
  parameter int LvlW    = 4,
  parameter int FsSetup = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_load_i,
  input  logic             tx_avail_i,
  input  logic [LvlW-1:0]  fifo_lvl_i,
  input  logic             tx_last_slot_i,
  input  logic             rx_last_slot_i,
  input  logic             bit_tick_i,
  input  logic             ext_fs_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o,
  output logic             fs_acc_o,
  output logic             irq_tx_err_o,
  output logic             irq_tx_o,
  output logic             irq_tls_o,
  output logic             irq_rls_o
);
  logic [DataW-1:0] ctrl_q, cfg_q;
  logic             tls_q, rls_q, tue, tdr;
  logic [NumTx-1:0] tx_en, txd_wr;
  logic             stat_rd, stat_wr, tslot_wr, net_mode;
  logic             ue_set, dr_set, tls_set, rls_set, wm_hit;
  logic             irq_ue_q, irq_dr_q, irq_tls_q, irq_rls_q;

  assign tx_en    = ctrl_q[NumTx-1:0];
  assign net_mode = cfg_q[CFG_NET];
  assign stat_rd  = bus_re_i & (bus_addr_i == ADDR_STAT);
  assign stat_wr  = bus_we_i & (bus_addr_i == ADDR_STAT);
  assign tslot_wr = bus_we_i & (bus_addr_i == ADDR_TSLOT);

  for (genvar i = 0; i < NumTx; i++) begin : g_txd
    assign txd_wr[i] = bus_we_i & (bus_addr_i == ADDR_TXD0 + 3'(i));
  end

  assign wm_hit  = fifo_lvl_i <= cfg_q[LvlW-1:0];
  assign ue_set  = tx_load_i & ~tx_avail_i;
  assign dr_set  = tx_load_i & (~ctrl_q[CTRL_FIFO] | wm_hit);
  assign tls_set = tx_last_slot_i & net_mode;
  assign rls_set = rx_last_slot_i & net_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else if (bus_we_i) begin
      if (bus_addr_i == ADDR_CTRL) ctrl_q <= bus_wdata_i;
      if (bus_addr_i == ADDR_CFG)  cfg_q  <= bus_wdata_i;
    end
  end

  ssi_seq_clear #(.NumTx(NumTx)) u_ue (
    .clk_i, .rst_ni, .set_i(ue_set), .rd_i(stat_rd), .wr_i(txd_wr),
    .en_i(tx_en), .force_clr_i(tslot_wr), .flag_o(tue)
  );

  ssi_seq_clear #(.NumTx(NumTx)) u_dr (
    .clk_i, .rst_ni, .set_i(dr_set), .rd_i(stat_rd), .wr_i(txd_wr),
    .en_i(tx_en), .force_clr_i(tslot_wr), .flag_o(tdr)
  );

  // last-slot flags: write-1-to-clear, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tls_q <= 1'b0;
      rls_q <= 1'b0;
    end else begin
      if (tls_set)                              tls_q <= 1'b1;
      else if (stat_wr && bus_wdata_i[STAT_TLS]) tls_q <= 1'b0;
      if (rls_set)                              rls_q <= 1'b1;
      else if (stat_wr && bus_wdata_i[STAT_RLS]) rls_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_ue_q  <= 1'b0;
      irq_dr_q  <= 1'b0;
      irq_tls_q <= 1'b0;
      irq_rls_q <= 1'b0;
    end else begin
      irq_ue_q  <= tue   & ctrl_q[CTRL_TIE];
      irq_dr_q  <= tdr   & ctrl_q[CTRL_TIE];
      irq_tls_q <= tls_q & ctrl_q[CTRL_TLIE];
      irq_rls_q <= rls_q & ctrl_q[CTRL_RLIE];
    end
  end

  assign irq_tx_err_o = irq_ue_q;
  assign irq_tx_o     = irq_dr_q;
  assign irq_tls_o    = irq_tls_q;
  assign irq_rls_o    = irq_rls_q;

  ssi_fs_gate #(.Setup(FsSetup)) u_fs (
    .clk_i, .rst_ni,
    .any_en_i(|tx_en | ctrl_q[CTRL_RXEN]),
    .tick_i(bit_tick_i), .fs_i(ext_fs_i), .fs_o(fs_acc_o)
  );

  always_comb begin
    case (bus_addr_i)
      ADDR_STAT: bus_rdata_o = {4'b0, rls_q, tls_q, tdr, tue};
      ADDR_CTRL: bus_rdata_o = ctrl_q;
      ADDR_CFG:  bus_rdata_o = cfg_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  p_tls_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tls_q && !(stat_wr && bus_wdata_i[STAT_TLS])) |=> tls_q);
  p_rls_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rls_q && !(stat_wr && bus_wdata_i[STAT_RLS])) |=> rls_q);
  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_err_o |-> $past(tue && ctrl_q[CTRL_TIE]));
  p_tls_net_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tls_q && !net_mode) |=> !tls_q);
endmodule

// File: tb/sim_ssi_irq_ctrl.sv
module sim_ssi_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_load = 0, tx_avail = 0, tx_last = 0, rx_last = 0, tick = 0, ext_fs = 0;
  logic [3:0] lvl = '0;
  logic we = 0, re = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic fs_acc, irq_err, irq_tx, irq_tls, irq_rls;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ssi_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_load_i(tx_load), .tx_avail_i(tx_avail),
    .fifo_lvl_i(lvl), .tx_last_slot_i(tx_last), .rx_last_slot_i(rx_last),
    .bit_tick_i(tick), .ext_fs_i(ext_fs), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fs_acc_o(fs_acc), .irq_tx_err_o(irq_err), .irq_tx_o(irq_tx),
    .irq_tls_o(irq_tls), .irq_rls_o(irq_rls)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    re = 1; addr = a;
    #1 d = rdata;
    step();
    re = 0;
  endtask

  task automatic load(input logic avail);
    tx_load = 1; tx_avail = avail;
    step();
    tx_load = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] s;
    step(2);
    rst_n = 1;
    step();
    // R1 reset state
    rd(0, s); chk(s == 0, "R1 status", s, 0);
    rd(1, s); chk(s == 0, "R1 ctrl", s, 0);
    rd(3, s); chk(s == 0, "R1 cfg", s, 0);
    chk({irq_err, irq_tx, irq_tls, irq_rls, fs_acc} == 0, "R1 outputs",
        {irq_err, irq_tx, irq_tls, irq_rls, fs_acc}, 0);

    // R2, R4, R9 underrun
    wr(1, 8'h17); wr(3, 8'h80);
    load(1'b1); step(2);
    rd(0, s); chk(s[0] == 0, "R2 avail no underrun", s[0], 0);
    wr(2, 0); step(2);
    load(1'b0); step(2);
    chk(irq_err == 1, "R2 R9 underrun irq", irq_err, 1);
    rd(0, s); chk(s[0] == 1, "R2 underrun flag", s[0], 1);
    wr(2, 0); step(2);
    rd(0, s); chk(s[1:0] == 0, "R4 tslot clears", s[1:0], 0);
    chk(irq_err == 0, "R4 irq cleared", irq_err, 0);

    // R9 enable gating
    wr(1, 8'h07); load(1'b0); step(2);
    chk(irq_err == 0 && irq_tx == 0, "R9 tie off", {irq_err, irq_tx}, 0);
    wr(1, 8'h17); step(2);
    chk(irq_err == 1 && irq_tx == 1, "R9 tie on", {irq_err, irq_tx}, 3);

    // R3 clear sequence for every enable mask
    for (int m = 1; m < 8; m++) begin
      int last;
      last = 0;
      for (int i = 0; i < 3; i++) if (m[i]) last = i;
      wr(1, 8'h10 | 8'(m)); wr(2, 0);
      load(1'b0); step(2);
      for (int i = 0; i < 3; i++) if (m[i]) wr(3'(4 + i), 8'h55);
      step(2);
      chk(irq_err == 1, "R3 write before read", irq_err, 1);
      rd(0, s);
      for (int i = 0; i < last; i++) if (m[i]) wr(3'(4 + i), 8'h55);
      step(2);
      chk(irq_err == 1, "R3 partial writes", irq_err, 1);
      wr(3'(4 + last), 8'h55); step(2);
      chk(irq_err == 0 && irq_tx == 0, "R3 sequence clears", {irq_err, irq_tx}, 0);
    end

    // R12 re-set while armed cancels
    wr(1, 8'h13); wr(2, 0);
    load(1'b0); step(2);
    rd(0, s);
    load(1'b0);
    wr(4, 1); wr(5, 1); step(2);
    chk(irq_err == 1, "R12 cancelled sequence", irq_err, 1);
    rd(0, s); wr(4, 1); wr(5, 1); step(2);
    chk(irq_err == 0, "R12 new sequence clears", irq_err, 0);

    // R5 fifo disabled: each load requests
    for (int k = 0; k < 3; k++) begin
      wr(2, 0); step();
      rd(0, s); chk(s[1] == 0, "R5 cleared", s[1], 0);
      load(1'b1); step();
      rd(0, s); chk(s[1] == 1, "R5 request per load", s[1], 1);
    end

    // R6 watermark sweep
    wr(1, 8'h97);
    for (int wm = 0; wm < 16; wm += 5) begin
      wr(3, 8'h80 | 8'(wm));
      for (int l = 0; l < 16; l++) begin
        wr(2, 0);
        lvl = 4'(l);
        load(1'b1); step();
        rd(0, s);
        chk(s[1] == (l <= wm), "R6 watermark", s[1], int'(l <= wm));
      end
    end
    wr(2, 0);

    // R7 transmit last slot
    wr(1, 8'h20); wr(3, 8'h80);
    tx_last = 1; step(); tx_last = 0; step(2);
    rd(0, s); chk(s[2] == 1, "R7 tls set", s[2], 1);
    chk(irq_tls == 1, "R7 R9 tls irq", irq_tls, 1);
    wr(0, 8'h08); wr(0, 8'h03); wr(2, 0); step();
    rd(0, s); chk(s[2] == 1, "R7 other writes ignored", s[2], 1);
    wr(0, 8'h04); step(2);
    rd(0, s); chk(s[2] == 0, "R7 w1c", s[2], 0);
    chk(irq_tls == 0, "R7 irq cleared", irq_tls, 0);
    wr(3, 8'h00);
    tx_last = 1; step(); tx_last = 0; step();
    rd(0, s); chk(s[2] == 0, "R7 not network", s[2], 0);

    // R8 receive last slot
    wr(3, 8'h80); wr(1, 8'h00);
    rx_last = 1; step(); rx_last = 0; step(2);
    rd(0, s); chk(s[3] == 1, "R8 rls set", s[3], 1);
    chk(irq_rls == 0, "R8 R9 rls irq masked", irq_rls, 0);
    wr(1, 8'h40); step(2);
    chk(irq_rls == 1, "R8 R9 rls irq", irq_rls, 1);
    wr(0, 8'h04); step();
    rd(0, s); chk(s[3] == 1, "R8 tls write ignored", s[3], 1);
    wr(0, 8'h08); step();
    rd(0, s); chk(s[3] == 0, "R8 w1c", s[3], 0);
    wr(3, 8'h00);
    rx_last = 1; step(); rx_last = 0; step();
    rd(0, s); chk(s[3] == 0, "R8 not network", s[3], 0);

    // R10 set beats clear in same cycle
    wr(3, 8'h80);
    we = 1; addr = 0; wdata = 8'h04; tx_last = 1;
    step(); we = 0; tx_last = 0; step();
    rd(0, s); chk(s[2] == 1, "R10 tls set wins", s[2], 1);
    wr(0, 8'h04);
    wr(1, 8'h01);
    we = 1; addr = 2; wdata = 0; tx_load = 1; tx_avail = 0;
    step(); we = 0; tx_load = 0; step();
    rd(0, s); chk(s[0] == 1, "R10 underrun set wins", s[0], 1);
    wr(2, 0);

    // R11 frame sync setup
    wr(1, 8'h08);
    ext_fs = 1;
    for (int k = 0; k < 7; k++) begin
      #1 chk(fs_acc == (k >= 4), "R11 fs after ticks", fs_acc, int'(k >= 4));
      tick = 1; step(); tick = 0; step();
    end
    wr(1, 8'h00); #1;
    chk(fs_acc == 0, "R11 disabled", fs_acc, 0);
    wr(1, 8'h02);
    tick = 1; step(3); tick = 0; #1;
    chk(fs_acc == 0, "R11 restart count", fs_acc, 0);
    tick = 1; step(); tick = 0; #1;
    chk(fs_acc == 1, "R11 accepted after restart", fs_acc, 1);
    ext_fs = 0;

    finish_run();
  end
endmodule